// File: doc/BRIEF.md
# Variable-Latency Five-Stage Integer Pipeline

This block is a compact in-order integer pipeline with five stages: fetch, decode, operand read, execute and write-back. It runs add, subtract, multiply and divide on an internal register file. A testbench or an upstream sequencer presents one instruction at a time on a valid/ready port. Each finished instruction leaves through a one-cycle retire strobe that carries its destination register and its result. A combinational debug port reads any register.

Fetch, decode, operand read and write-back each take one cycle. The execute stage holds an instruction for a number of cycles that depends on the opcode. While execute is busy, every earlier stage that holds an instruction keeps it, and write-back receives empty slots. A result leaving execute is forwarded straight into the operands of the instruction that enters execute on the same edge. An older result being written back is seen by operand read through a write-through register file. So a dependent instruction never waits longer than the structural stall.

Top module: `vlpipe_top`

## Requirements
- R1: On an empty pipeline, an instruction accepted so that it sits in fetch during cycle 1 is in decode in cycle 2, operand read in cycle 3, and execute from cycle 4. A one-cycle operation retires (write-back) in cycle 5.
- R2: Opcode encoding on `instrOp`: 2'b00 add, 2'b01 subtract, 2'b10 multiply, 2'b11 divide. Execute holds add and subtract for 1 cycle, multiply for 3 cycles and divide for 6 cycles. Write-back follows in the next cycle.
- R3: While execute is busy, every earlier occupied stage keeps its instruction, and `instrReady` is low exactly when fetch cannot advance. With back-to-back issue, instruction i (counting from 0) starts execute in cycle max(start(i-1)+lat(i-1), i+4) and retires at start(i)+lat(i).
- R4: A result that completes execute is forwarded to the next instruction entering execute, so read-after-write dependencies through either source operand give correct values with no added cycles.
- R5: The sequence MUL r2,r0,r1; DIV r5,r3,r4; ADD r2,r5,r2; SUB r5,r2,r6 retires in cycles 7, 13, 14 and 15.
- R6: Arithmetic is on 16-bit unsigned values. Add and subtract wrap modulo 2^16, multiply keeps the low 16 bits of the product, and divide returns the unsigned quotient of source 1 by source 2.
- R7: Division by zero returns 16'hFFFF.
- R8: The register file has 8 registers of 16 bits. After reset register k holds (5 + 11*k) mod 2^16. `dbgData` shows the register addressed by `dbgAddr` in the same cycle.
- R9: Each accepted instruction raises `retireValid` for exactly one cycle, in program order, with `retireRd` and `retireData` equal to its destination and result. Empty slots never write a register or strobe retire. Inputs offered with `instrValid` low are ignored.
- R10: A register read in operand read during the same cycle that write-back writes that register returns the new value.
- R11: During and right after reset, `instrReady` is high and `retireValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | An instruction is offered this cycle |
| instrOp | input | 2 | Opcode (00 add, 01 sub, 10 mul, 11 div) |
| instrRd | input | 3 | Destination register |
| instrRs1 | input | 3 | Source register 1 |
| instrRs2 | input | 3 | Source register 2 |
| instrReady | output | 1 | Fetch can take an instruction on this edge |
| retireValid | output | 1 | One instruction writes back this cycle |
| retireRd | output | 3 | Destination of the retiring instruction |
| retireData | output | 16 | Result of the retiring instruction |
| dbgAddr | input | 3 | Debug read address |
| dbgData | output | 16 | Register contents at `dbgAddr` |

## Verification
Every ordered pair of the four opcodes is issued back to back three times: once with no dependency, once with the second instruction reading the first result as source 1, and once as source 2. This separates a stall-length fault from a forwarding fault on either operand mux. A single add, the four-instruction reference sequence and a divide by a freshly zeroed register pin the fill latency, the stall chain and the zero-divisor value. A dependency at distance two relies only on the write-through read. A long generated stream mixes every latency and hazard distance, and an idle phase with `instrValid` low shows that nothing is fetched.

// File: rtl/vlpipe_pkg.sv
package vlpipe_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } opcode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic ifLoad;    // fetch register captures the input port
    logic idLoad;    // decode register captures fetch
    logic ofLoad;    // operand-read register captures decode
    logic poLoad;    // execute register captures operand read
    logic fwdEn;     // execute result is final this cycle (forward + move on)
    logic regWrite;  // write-back stage holds a real instruction
  } pipe_strobe_t;

endpackage

// File: rtl/vlpipe_regfile.sv
module vlpipe_regfile #(
  parameter int DATA_W   = 16,
  parameter int REG_N    = 8,
  parameter int NRD      = 3,
  parameter int RST_BASE = 5,
  parameter int RST_STEP = 11,
  localparam int AW      = $clog2(REG_N)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [REG_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < REG_N; k++) begin
        mem[k] <= DATA_W'(RST_BASE + k * RST_STEP);
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Write-through read ports
  for (genvar g = 0; g < NRD; g++) begin : gRead
    always_comb begin
      if (we && (waddr == raddr[g])) rdata[g] = wdata;
      else                           rdata[g] = mem[raddr[g]];
    end
  end

endmodule

// File: rtl/vlpipe_alu.sv
module vlpipe_alu
  import vlpipe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (op)
      OP_ADD: result = srcA + srcB;
      OP_SUB: result = srcA - srcB;
      OP_MUL: result = srcA * srcB;
      default: begin
        if (srcB == '0) result = '1;
        else            result = srcA / srcB;
      end
    endcase
  end

endmodule

// File: rtl/vlpipe_ctrl.sv
module vlpipe_ctrl
  import vlpipe_pkg::*;
#(
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 6,
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                               : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD),
  localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrValid,
  input  opcode_e      ofOp,
  input  opcode_e      poOp,
  output logic         instrReady,
  output logic         retireValid,
  output pipe_strobe_t strobe
);

  logic ifV, idV, ofV, poV, woV;
  logic [CNT_W-1:0] remCnt;
  logic [CNT_W-1:0] ageCnt;
  logic poBusy, poDone, ofHold, idHold, ifHold;

  function automatic logic [CNT_W-1:0] extraCycles(opcode_e op);
    unique case (op)
      OP_MUL:  return CNT_W'(LAT_MUL - 1);
      OP_DIV:  return CNT_W'(LAT_DIV - 1);
      default: return CNT_W'(LAT_ADD - 1);
    endcase
  endfunction

  // Backward stall chain
  always_comb begin
    poBusy = poV && (remCnt != '0);
    poDone = poV && (remCnt == '0);
    ofHold = ofV && poBusy;
    idHold = idV && ofHold;
    ifHold = ifV && idHold;
  end

  assign instrReady  = !ifHold;
  assign retireValid = woV;

  always_comb begin
    strobe.ifLoad   = !ifHold;
    strobe.idLoad   = !idHold;
    strobe.ofLoad   = !ofHold;
    strobe.poLoad   = !poBusy;
    strobe.fwdEn    = poDone;
    strobe.regWrite = woV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifV    <= 1'b0;
      idV    <= 1'b0;
      ofV    <= 1'b0;
      poV    <= 1'b0;
      woV    <= 1'b0;
      remCnt <= '0;
      ageCnt <= '0;
    end else begin
      if (!ifHold) ifV <= instrValid;
      if (!idHold) idV <= ifV;
      if (!ofHold) ofV <= idV;
      if (poBusy) begin
        remCnt <= remCnt - 1'b1;
        ageCnt <= ageCnt + 1'b1;
      end else begin
        poV    <= ofV;
        remCnt <= ofV ? extraCycles(ofOp) : '0;
        ageCnt <= '0;
      end
      // a bubble enters write-back while execute is still working
      woV <= poDone;
    end
  end

  // Occupancy measured by an up-counter independent of the down-counter
  p_exec_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    poDone |-> (ageCnt == extraCycles(poOp)));

  p_of_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ofV && poBusy) |=> ofV);

  p_ready_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    !instrReady |-> (ifV && idV && ofV && poV));

  p_wb_bubble_r9: assert property (@(posedge clk) disable iff (!rstN)
    (poV && !poDone) |=> !retireValid);

endmodule

// File: rtl/vlpipe_dpath.sv
module vlpipe_dpath
  import vlpipe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_N    = 8,
  parameter int RST_BASE = 5,
  parameter int RST_STEP = 11,
  localparam int AW      = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipe_strobe_t      strobe,
  input  logic [1:0]        instrOp,
  input  logic [AW-1:0]     instrRd,
  input  logic [AW-1:0]     instrRs1,
  input  logic [AW-1:0]     instrRs2,
  output opcode_e           ofOpOut,
  output opcode_e           poOpOut,
  output logic [AW-1:0]     retireRd,
  output logic [DATA_W-1:0] retireData,
  input  logic [AW-1:0]     dbgAddr,
  output logic [DATA_W-1:0] dbgData
);

  localparam int NRD = 3;

  opcode_e           ifOp, idOp, ofOp, poOp;
  logic [AW-1:0]     ifRd, idRd, ofRd, poRd, woRd;
  logic [AW-1:0]     ifRs1, idRs1, ofRs1;
  logic [AW-1:0]     ifRs2, idRs2, ofRs2;
  logic [DATA_W-1:0] poA, poB, woData, aluRes;
  logic [DATA_W-1:0] fwdA, fwdB;
  logic [NRD-1:0][AW-1:0]     rfAddr;
  logic [NRD-1:0][DATA_W-1:0] rfData;

  assign ofOpOut    = ofOp;
  assign poOpOut    = poOp;
  assign retireRd   = woRd;
  assign retireData = woData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifOp <= OP_ADD; ifRd <= '0; ifRs1 <= '0; ifRs2 <= '0;
      idOp <= OP_ADD; idRd <= '0; idRs1 <= '0; idRs2 <= '0;
      ofOp <= OP_ADD; ofRd <= '0; ofRs1 <= '0; ofRs2 <= '0;
      poOp <= OP_ADD; poRd <= '0; poA   <= '0; poB   <= '0;
      woRd <= '0;     woData <= '0;
    end else begin
      if (strobe.ifLoad) begin
        ifOp <= opcode_e'(instrOp); ifRd <= instrRd; ifRs1 <= instrRs1; ifRs2 <= instrRs2;
      end
      if (strobe.idLoad) begin
        idOp <= ifOp; idRd <= ifRd; idRs1 <= ifRs1; idRs2 <= ifRs2;
      end
      if (strobe.ofLoad) begin
        ofOp <= idOp; ofRd <= idRd; ofRs1 <= idRs1; ofRs2 <= idRs2;
      end
      if (strobe.poLoad) begin
        poOp <= ofOp; poRd <= ofRd; poA <= fwdA; poB <= fwdB;
      end
      if (strobe.fwdEn) begin
        woRd <= poRd; woData <= aluRes;
      end
    end
  end

  // Execute-to-execute forwarding muxes
  always_comb begin
    fwdA = (strobe.fwdEn && (poRd == ofRs1)) ? aluRes : rfData[0];
    fwdB = (strobe.fwdEn && (poRd == ofRs2)) ? aluRes : rfData[1];
  end

  always_comb begin
    rfAddr[0] = ofRs1;
    rfAddr[1] = ofRs2;
    rfAddr[2] = dbgAddr;
  end
  assign dbgData = rfData[2];

  vlpipe_regfile #(
    .DATA_W(DATA_W), .REG_N(REG_N), .NRD(NRD),
    .RST_BASE(RST_BASE), .RST_STEP(RST_STEP)
  ) rf_i (
    .clk(clk), .rstN(rstN),
    .we(strobe.regWrite), .waddr(woRd), .wdata(woData),
    .raddr(rfAddr), .rdata(rfData)
  );

  vlpipe_alu #(.DATA_W(DATA_W)) alu_i (
    .op(poOp), .srcA(poA), .srcB(poB), .result(aluRes)
  );

  // A held fetch slot keeps its instruction
  p_if_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ifLoad |=> ($stable(ifOp) && $stable(ifRd) && $stable(ifRs1) && $stable(ifRs2)));

  // Operands stay frozen during a multicycle operation
  p_po_operands_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.poLoad |=> ($stable(poA) && $stable(poB) && $stable(poOp)));

endmodule

// File: rtl/vlpipe_top.sv
module vlpipe_top
  import vlpipe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_N    = 8,
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 6,
  parameter int RST_BASE = 5,
  parameter int RST_STEP = 11,
  localparam int AW      = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [1:0]        instrOp,
  input  logic [AW-1:0]     instrRd,
  input  logic [AW-1:0]     instrRs1,
  input  logic [AW-1:0]     instrRs2,
  output logic              instrReady,
  output logic              retireValid,
  output logic [AW-1:0]     retireRd,
  output logic [DATA_W-1:0] retireData,
  input  logic [AW-1:0]     dbgAddr,
  output logic [DATA_W-1:0] dbgData
);

  pipe_strobe_t strobe;
  opcode_e      ofOp, poOp;

  vlpipe_ctrl #(
    .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .ofOp(ofOp), .poOp(poOp),
    .instrReady(instrReady), .retireValid(retireValid), .strobe(strobe)
  );

  vlpipe_dpath #(
    .DATA_W(DATA_W), .REG_N(REG_N), .RST_BASE(RST_BASE), .RST_STEP(RST_STEP)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .instrOp(instrOp), .instrRd(instrRd), .instrRs1(instrRs1), .instrRs2(instrRs2),
    .ofOpOut(ofOp), .poOpOut(poOp),
    .retireRd(retireRd), .retireData(retireData),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

endmodule

// File: tb/vlpipe_tb.sv
module vlpipe_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [1:0]  instrOp = '0;
  logic [2:0]  instrRd = '0, instrRs1 = '0, instrRs2 = '0;
  logic        instrReady, retireValid;
  logic [2:0]  retireRd;
  logic [15:0] retireData;
  logic [2:0]  dbgAddr = '0;
  logic [15:0] dbgData;

  vlpipe_top dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrOp(instrOp),
    .instrRd(instrRd), .instrRs1(instrRs1), .instrRs2(instrRs2),
    .instrReady(instrReady), .retireValid(retireValid), .retireRd(retireRd),
    .retireData(retireData), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  int baseCyc = 0;
  int rcount = 0;

  int pOp[64], pRd[64], pRs1[64], pRs2[64];
  int expCyc[64], expRd[64];
  logic [15:0] expData[64];
  int gotCyc[64], gotRd[64];
  logic [15:0] gotData[64];
  logic [15:0] model[8];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && retireValid) begin
      if (rcount < 64) begin
        gotCyc[rcount]  = cyc - baseCyc + 1;
        gotRd[rcount]   = int'(retireRd);
        gotData[rcount] = retireData;
      end
      rcount = rcount + 1;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int latOf(int op);
    return (op == 2) ? 3 : (op == 3) ? 6 : 1;
  endfunction

  function automatic logic [15:0] calc(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 16'd0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  task automatic setInstr(int i, int op, int rd, int rs1, int rs2);
    pOp[i] = op; pRd[i] = rd; pRs1[i] = rs1; pRs2[i] = rs2;
  endtask

  // Issue n instructions back to back, then compare every retire
  task automatic runProgram(int n, string tag);
    int start;
    int prevStart;
    prevStart = 0;
    for (int i = 0; i < n; i++) begin
      expData[i] = calc(pOp[i], model[pRs1[i]], model[pRs2[i]]);
      model[pRd[i]] = expData[i];
      expRd[i] = pRd[i];
      start = (i == 0) ? 4 : prevStart + latOf(pOp[i-1]);
      if (start < i + 4) start = i + 4;
      expCyc[i] = start + latOf(pOp[i]);
      prevStart = start;
    end
    rcount = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instrValid = 1'b1;
      instrOp  = 2'(pOp[i]);
      instrRd  = 3'(pRd[i]);
      instrRs1 = 3'(pRs1[i]);
      instrRs2 = 3'(pRs2[i]);
      while (!instrReady) @(negedge clk);
      if (i == 0) baseCyc = cyc + 1;
      @(posedge clk);
    end
    @(negedge clk);
    instrValid = 1'b0;
    for (int w = 0; w < 200 && rcount < n; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rcount == n, {tag, " R9 retire count"}, rcount, n);
    for (int i = 0; i < n && i < rcount; i++) begin
      check(gotCyc[i] == expCyc[i], {tag, " R3 retire cycle"}, gotCyc[i], expCyc[i]);
      check(gotRd[i] == expRd[i], {tag, " R9 retire dest"}, gotRd[i], expRd[i]);
      check(gotData[i] == expData[i], {tag, " R4 R6 retire value"}, gotData[i], expData[i]);
    end
  endtask

  task automatic checkRegs(string tag);
    for (int k = 0; k < 8; k++) begin
      dbgAddr = 3'(k);
      #1;
      check(dbgData == model[k], {tag, " R8 register"}, dbgData, model[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 16'(5 + 11 * k);
    repeat (3) @(negedge clk);
    // R11: reset state
    check(instrReady == 1'b1, "R11 ready in reset", instrReady, 1);
    check(retireValid == 1'b0, "R11 no retire in reset", retireValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(instrReady == 1'b1, "R11 ready after reset", instrReady, 1);
    check(retireValid == 1'b0, "R11 no retire after reset", retireValid, 0);
    checkRegs("reset");

    // R1: single add on an empty pipeline retires in cycle 5
    setInstr(0, 0, 7, 1, 2);
    runProgram(1, "R1 single");
    check(gotCyc[0] == 5, "R1 fill latency", gotCyc[0], 5);

    // R5: reference sequence
    setInstr(0, 2, 2, 0, 1);
    setInstr(1, 3, 5, 3, 4);
    setInstr(2, 0, 2, 5, 2);
    setInstr(3, 1, 5, 2, 6);
    runProgram(4, "R5 seq");
    check(gotCyc[3] == 15, "R5 last write-back", gotCyc[3], 15);
    check(gotCyc[1] == 13, "R5 divide write-back", gotCyc[1], 13);

    // R7: divide by a zeroed register
    setInstr(0, 1, 7, 1, 1);
    setInstr(1, 3, 6, 3, 7);
    runProgram(2, "R7 divzero");
    check(gotData[1] == 16'hFFFF, "R7 zero divisor", gotData[1], 16'hFFFF);
    checkRegs("R7");

    // R10: distance-two dependency through write-through read
    setInstr(0, 0, 1, 3, 4);
    setInstr(1, 0, 0, 6, 6);
    setInstr(2, 1, 4, 1, 3);
    runProgram(3, "R10 wt");

    // R2 R3 R4: every ordered opcode pair, three dependency shapes
    for (int o1 = 0; o1 < 4; o1++) begin
      for (int o2 = 0; o2 < 4; o2++) begin
        for (int dep = 0; dep < 3; dep++) begin
          model[3] = model[3];
          setInstr(0, o1, 2, 3, 4);
          setInstr(1, o2, 5, (dep == 1) ? 2 : 6, (dep == 2) ? 2 : 1);
          setInstr(2, 0, 4, 0, 6);
          runProgram(3, "R2 pair");
        end
      end
    end

    // R9: offered inputs with valid low are ignored
    rcount = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      instrValid = 1'b0;
      instrOp = 2'(i); instrRd = 3'(i); instrRs1 = 3'(i + 1); instrRs2 = 3'(i + 2);
    end
    repeat (10) @(negedge clk);
    check(rcount == 0, "R9 idle no retire", rcount, 0);
    checkRegs("R9 idle");

    // Long mixed stream
    for (int i = 0; i < 40; i++) begin
      setInstr(i, (i * 7 + 3) % 4, (i * 3 + 1) % 8,
               (i % 3 == 0 && i > 0) ? (((i - 1) * 3 + 1) % 8) : ((i * 5 + 2) % 8),
               (i % 4 == 1) ? (((i - 1) * 3 + 1) % 8) : ((i * 3 + 6) % 8));
    end
    runProgram(40, "R3 stream");
    checkRegs("final");
    finishRun();
  end

endmodule